// File: doc/BRIEF.md
# Program Counter and Hardware Stack Sequencer

This block keeps the instruction address of a small processor and the pointer of its hardware stack. Each clock the surrounding control logic presents one action code. The block either holds the program counter, advances it by one, loads an absolute target, or takes a signed relative branch when a selected status flag matches the wanted polarity. It can also push or pop a data byte, call a subroutine, or return from one. Instruction fetch, decoding and arithmetic live elsewhere.

The program counter is 16 bits wide and counts instruction words. The stack pointer is 16 bits wide and addresses bytes in data memory. It starts at the top of internal data memory (0x10FF) and grows toward lower addresses. All stack traffic goes through one synchronous single-port memory interface, and read data returns one cycle after the read is issued. A call spends two cycles and a return spends three. During the extra cycles `busy` is high and the action inputs are ignored.

Top module: `pcsu_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pc` becomes 0x0000, `sp` becomes 0x10FF, and `busy` and `pop_valid` become 0.
- R2: Action codes are 0 hold, 1 step, 2 jump, 3 branch, 4 call, 5 return, 6 push and 7 pop. Hold leaves `pc` unchanged. Step, push and pop each add one to `pc`.
- R3: A jump loads `pc` with `target` at the next edge.
- R4: A branch whose condition is true loads `pc` + sign-extended `offset` + 1. A branch whose condition is false loads `pc` + 1.
- R5: Condition encoding. `cond_sel[2:1]` picks the flag: 0 selects Z (`flags[0]`), 1 selects C (`flags[1]`), 2 selects N (`flags[2]`), and 3 means the branch is never taken. `cond_sel[0]` = 1 branches when the flag is 1, and 0 branches when the flag is 0.
- R6: A push writes `push_data` to address `sp` and then decrements `sp`.
- R7: A pop reads address `sp`+1 and increments `sp`. In the following cycle `pop_valid` is 1 and `pop_data` carries the byte.
- R8: A call writes the low byte of `pc`+1 at `sp` in its first cycle, with `busy` low and `pc` held. In its second cycle, with `busy` high, it writes the high byte at `sp`-1. After that cycle `sp` has dropped by 2 and `pc` equals the target captured in the first cycle.
- R9: A return reads the high byte at `sp`+1 and then the low byte at `sp`+2, with `busy` high for two cycles. `pc` takes the restored value at the end of the third cycle, and `sp` has risen by 2.
- R10: Action inputs presented while `busy` is high have no effect on `pc`, `sp` or memory.
- R11: The memory port never writes and reads in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act | input | 3 | Action code |
| target | input | 16 | Absolute jump or call target |
| offset | input | 12 | Signed relative branch distance |
| cond_sel | input | 3 | Branch flag select and polarity |
| flags | input | 3 | Status flags {N,C,Z} |
| push_data | input | 8 | Byte to push |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Multi-cycle call or return in progress |
| pop_data | output | 8 | Popped byte |
| pop_valid | output | 1 | `pop_data` valid this cycle |
| mem_addr | output | 16 | Data memory byte address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |

## Verification
Two activities can share one cycle and one memory port: the data returning from a pop, and the next action's own stack access. The bench provokes this by issuing a pop immediately followed by a push, a call or a return. It then checks that `pop_data` matches the reference model's byte in that same cycle, while the new write or read lands at the model's address. A second overlap is a new action presented during the busy cycles of a call or return. The bench drives jumps and pushes there and requires `pc`, `sp` and later stack reads to match a model that discards them.

// File: rtl/pcsu_pkg.sv
// Shared action codes and widths for the program counter / stack unit.
// Assumes a byte-wide data memory and a program counter of two bytes.
package pcsu_pkg;
    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,
        ACT_STEP   = 3'd1,
        ACT_JUMP   = 3'd2,
        ACT_BRANCH = 3'd3,
        ACT_CALL   = 3'd4,
        ACT_RET    = 3'd5,
        ACT_PUSH   = 3'd6,
        ACT_POP    = 3'd7
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CALL_HI = 2'd1,
        ST_RET_LO  = 2'd2,
        ST_RET_FIN = 2'd3
    } seq_e;
endpackage

// File: rtl/pcsu_cond.sv
// Branch condition evaluator: selects one status flag and compares it with
// the wanted polarity. Assumes flags = {N,C,Z}; select 3 never branches.
module pcsu_cond #(
    parameter int FLAG_N = 3
) (
    input  logic [2:0]        cond_sel,
    input  logic [FLAG_N-1:0] flags,
    output logic              taken
);
    // Pick the flag and test it against the polarity bit.
    always_comb begin
        taken = 1'b0;
        if (cond_sel[2:1] < 2'(FLAG_N))
            taken = (flags[cond_sel[2:1]] == cond_sel[0]);
    end
endmodule

// File: rtl/pcsu_pcadd.sv
// Program counter arithmetic: the next sequential address and the relative
// branch target pc + sign-extended offset + 1. Wraps modulo 2^PC_W.
module pcsu_pcadd #(
    parameter int PC_W  = 16,
    parameter int OFS_W = 12
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFS_W-1:0] offset,
    output logic [PC_W-1:0]  pc_inc,
    output logic [PC_W-1:0]  pc_rel
);
    localparam int EXT_W = PC_W - OFS_W;
    logic [PC_W-1:0] ofs_ext;

    // Sign-extend the offset and form both candidate addresses.
    always_comb begin
        ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
        pc_inc  = pc + PC_W'(1);
        pc_rel  = pc_inc + ofs_ext;
    end
endmodule

// File: rtl/pcsu_sp.sv
// Stack pointer register: resets to the top of data memory, moves down on a
// write to the stack and up on a read. Assumes inc and dec are exclusive.
module pcsu_sp #(
    parameter int          SP_W   = 16,
    parameter logic [15:0] SP_TOP = 16'h10FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            dec,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_up
);
    assign sp_up = sp + SP_W'(1);

    // Update the pointer on each stack access.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= SP_W'(SP_TOP);
        else if (inc) sp <= sp_up;
        else if (dec) sp <= sp - SP_W'(1);
    end
endmodule

// File: rtl/pcsu_top.sv
// Program counter and hardware stack sequencer. Applies one action per idle
// cycle; calls take two cycles and returns three, during which the action
// inputs are ignored. Assumes memory read data arrives one cycle after mem_re.
module pcsu_top
    import pcsu_pkg::*;
#(
    parameter int          PC_W   = 16,
    parameter int          SP_W   = 16,
    parameter int          DW     = 8,
    parameter int          OFS_W  = 12,
    parameter int          FLAG_N = 3,
    parameter logic [15:0] SP_TOP = 16'h10FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        act,
    input  logic [PC_W-1:0]   target,
    input  logic [OFS_W-1:0]  offset,
    input  logic [2:0]        cond_sel,
    input  logic [FLAG_N-1:0] flags,
    input  logic [DW-1:0]     push_data,
    output logic [PC_W-1:0]   pc,
    output logic [SP_W-1:0]   sp,
    output logic              busy,
    output logic [DW-1:0]     pop_data,
    output logic              pop_valid,
    output logic [SP_W-1:0]   mem_addr,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_re,
    input  logic [DW-1:0]     mem_rdata
);
    localparam int HALF = PC_W / 2;

    seq_e            state;
    act_e            a;
    logic            idle, taken, sp_inc, sp_dec;
    logic [PC_W-1:0] pc_inc, pc_rel, tgt_q;
    logic [HALF-1:0] hi_q;
    logic [SP_W-1:0] sp_up;

    assign a         = act_e'(act);
    assign idle      = (state == ST_IDLE);
    assign busy      = !idle;
    assign pop_data  = mem_rdata;

    pcsu_cond #(.FLAG_N(FLAG_N)) u_cond (
        .cond_sel(cond_sel), .flags(flags), .taken(taken));

    pcsu_pcadd #(.PC_W(PC_W), .OFS_W(OFS_W)) u_add (
        .pc(pc), .offset(offset), .pc_inc(pc_inc), .pc_rel(pc_rel));

    pcsu_sp #(.SP_W(SP_W), .SP_TOP(SP_TOP)) u_sp (
        .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec),
        .sp(sp), .sp_up(sp_up));

    // Drive the memory port and pointer moves for the current cycle.
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp;
        mem_wdata = '0;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (a == ACT_CALL) begin
                    mem_we = 1'b1; mem_wdata = pc_inc[HALF-1:0]; sp_dec = 1'b1;
                end else if (a == ACT_PUSH) begin
                    mem_we = 1'b1; mem_wdata = push_data; sp_dec = 1'b1;
                end else if (a == ACT_RET || a == ACT_POP) begin
                    mem_re = 1'b1; mem_addr = sp_up; sp_inc = 1'b1;
                end
            end
            ST_CALL_HI: begin
                mem_we = 1'b1; mem_wdata = hi_q; sp_dec = 1'b1;
            end
            ST_RET_LO: begin
                mem_re = 1'b1; mem_addr = sp_up; sp_inc = 1'b1;
            end
            default: ;
        endcase
    end

    // Sequence state, program counter and captured return bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pc        <= '0;
            tgt_q     <= '0;
            hi_q      <= '0;
            pop_valid <= 1'b0;
        end else begin
            pop_valid <= idle && (a == ACT_POP);
            unique case (state)
                ST_IDLE: begin
                    unique case (a)
                        ACT_HOLD:   ;
                        ACT_JUMP:   pc <= target;
                        ACT_BRANCH: pc <= taken ? pc_rel : pc_inc;
                        ACT_CALL: begin
                            tgt_q <= target;
                            hi_q  <= pc_inc[PC_W-1:HALF];
                            state <= ST_CALL_HI;
                        end
                        ACT_RET:    state <= ST_RET_LO;
                        default:    pc <= pc_inc;
                    endcase
                end
                ST_CALL_HI: begin
                    pc    <= tgt_q;
                    state <= ST_IDLE;
                end
                ST_RET_LO: begin
                    hi_q  <= mem_rdata;
                    state <= ST_RET_FIN;
                end
                default: begin
                    pc    <= {hi_q, mem_rdata};
                    state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/pcsu_chk.sv
// Port-level property checker for pcsu_top, attached by bind.
module pcsu_chk #(
    parameter int PC_W = 16,
    parameter int SP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      act,
    input logic [PC_W-1:0] target,
    input logic [PC_W-1:0] pc,
    input logic [SP_W-1:0] sp,
    input logic            busy,
    input logic            pop_valid,
    input logic            mem_we,
    input logic            mem_re
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && sp == SP_W'(16'h10FF) && !busy && !pop_valid));

    // R3
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && act == 3'd2) |=> (pc == $past(target)));

    // R6
    push_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && act == 3'd6) |=> (sp == $past(sp) - SP_W'(1)));

    // R7
    pop_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && act == 3'd7) |=> (pop_valid && sp == $past(sp) + SP_W'(1)));

    // R8
    call_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && act == 3'd4) |=> (busy && $stable(pc)));

    // R11
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
endmodule

bind pcsu_top pcsu_chk #(.PC_W(PC_W), .SP_W(SP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .act(act), .target(target), .pc(pc),
    .sp(sp), .busy(busy), .pop_valid(pop_valid),
    .mem_we(mem_we), .mem_re(mem_re));

// File: tb/sim_pcsu_top.sv
// Bench for pcsu_top: behavioural reference model compared every clock.
module sim_pcsu_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  act = '0;
    logic [15:0] target = '0;
    logic [11:0] offset = '0;
    logic [2:0]  cond_sel = '0;
    logic [2:0]  flags = '0;
    logic [7:0]  push_data = '0;
    logic [15:0] pc, sp, mem_addr;
    logic        busy, pop_valid, mem_we, mem_re;
    logic [7:0]  pop_data, mem_wdata, mem_rdata;

    logic [7:0]  ram [0:4095];
    byte unsigned mm [int];
    int          m_pc, m_sp;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcsu_top u0 (
        .clk(clk), .rst_n(rst_n), .act(act), .target(target), .offset(offset),
        .cond_sel(cond_sel), .flags(flags), .push_data(push_data),
        .pc(pc), .sp(sp), .busy(busy), .pop_data(pop_data),
        .pop_valid(pop_valid), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata));

    // Synchronous single-port data memory.
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr[11:0]];
    end

    function automatic byte unsigned rd(int a);
        return mm.exists(a & 16'hFFFF) ? mm[a & 16'hFFFF] : 8'h00;
    endfunction

    task automatic chk(string r, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", r, got, exp);
        end
    endtask

    // Compare architectural state with the model after an edge.
    task automatic cmp(string r, bit exp_busy);
        chk({r, " pc"}, pc, m_pc);
        chk({r, " sp"}, sp, m_sp);
        chk({r, " busy"}, busy, exp_busy);
    endtask

    task automatic drive(int a, int t, int k, int cs, int fl, int pd);
        act = 3'(a); target = 16'(t); offset = 12'(k);
        cond_sel = 3'(cs); flags = 3'(fl); push_data = 8'(pd);
        @(posedge clk);
        @(negedge clk);
    endtask

    // One idle-cycle action with its model update and checks.
    task automatic one(string r, int a, int t, int k, int cs, int fl, int pd);
        int pop_exp;
        bit tk;
        pop_exp = -1;
        drive(a, t, k, cs, fl, pd);
        case (a)
            1: m_pc = (m_pc + 1) & 16'hFFFF;
            2: m_pc = t & 16'hFFFF;
            3: begin
                tk = 0;
                if (cs[2:1] != 3) tk = (((fl >> cs[2:1]) & 1) == (cs & 1));
                if (tk) m_pc = (m_pc + 1 + ((k & 12'h800) ? k - 4096 : k)) & 16'hFFFF;
                else    m_pc = (m_pc + 1) & 16'hFFFF;
            end
            6: begin
                mm[m_sp] = 8'(pd); m_sp = (m_sp - 1) & 16'hFFFF;
                m_pc = (m_pc + 1) & 16'hFFFF;
            end
            7: begin
                m_sp = (m_sp + 1) & 16'hFFFF; pop_exp = rd(m_sp);
                m_pc = (m_pc + 1) & 16'hFFFF;
            end
            default: ;
        endcase
        cmp(r, 1'b0);
        chk({r, " pop_valid"}, pop_valid, pop_exp >= 0);
        if (pop_exp >= 0) chk({r, " pop_data"}, pop_data, pop_exp);
    endtask

    // Call with junk actions during the busy cycle (R8, R10).
    task automatic do_call(int t);
        int ret;
        ret = (m_pc + 1) & 16'hFFFF;
        drive(4, t, 0, 0, 0, 0);
        mm[m_sp] = 8'(ret); m_sp = (m_sp - 1) & 16'hFFFF;
        cmp("R8 call first", 1'b1);
        drive(6, 16'hDEAD, 0, 0, 0, 8'hEE);
        mm[m_sp] = 8'(ret >> 8); m_sp = (m_sp - 1) & 16'hFFFF;
        m_pc = t & 16'hFFFF;
        cmp("R8 R10 call second", 1'b0);
    endtask

    // Return with junk actions during the busy cycles (R9, R10).
    task automatic do_ret();
        int hi, lo;
        drive(5, 0, 0, 0, 0, 0);
        m_sp = (m_sp + 1) & 16'hFFFF; hi = rd(m_sp);
        cmp("R9 ret first", 1'b1);
        drive(2, 16'hBEEF, 0, 0, 0, 0);
        m_sp = (m_sp + 1) & 16'hFFFF; lo = rd(m_sp);
        cmp("R9 R10 ret second", 1'b1);
        drive(6, 0, 0, 0, 0, 8'h77);
        m_pc = (hi << 8) | lo;
        cmp("R9 R10 ret third", 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) ram[i] = 8'h00;
        m_pc = 0; m_sp = 16'h10FF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R1 reset", 1'b0);
        chk("R1 pop_valid", pop_valid, 0);
        rst_n = 1'b1;

        one("R2 hold", 0, 0, 0, 0, 0, 0);
        one("R2 step", 1, 0, 0, 0, 0, 0);
        one("R2 step", 1, 0, 0, 0, 0, 0);
        one("R3 jump", 2, 16'h0400, 0, 0, 0, 0);
        // R4 R5 every flag, both polarities, both flag values
        for (int cs = 0; cs < 8; cs++)
            for (int fl = 0; fl < 8; fl += 7)
                one("R4 R5 branch", 3, 0, 12'h010, cs, fl ^ (cs & 1 ? 0 : 5), 0);
        one("R4 backward", 3, 0, 12'hFF0, 3'b001, 3'b001, 0);
        one("R4 edge neg", 3, 0, 12'h800, 3'b011, 3'b010, 0);
        one("R4 edge pos", 3, 0, 12'h7FF, 3'b100, 3'b000, 0);
        one("R5 never", 3, 0, 12'h7FF, 3'b111, 3'b111, 0);
        one("R6 push", 6, 0, 0, 0, 0, 8'hA5);
        one("R6 push", 6, 0, 0, 0, 0, 8'h3C);
        one("R7 pop", 7, 0, 0, 0, 0, 0);
        one("R7 pop then push", 6, 0, 0, 0, 0, 8'h99);
        one("R7 pop", 7, 0, 0, 0, 0, 0);
        do_call(16'h1234);
        one("R2 step in sub", 1, 0, 0, 0, 0, 0);
        do_call(16'h2000);
        do_ret();
        do_ret();
        one("R7 pop", 7, 0, 0, 0, 0, 0);
        one("R7 pop", 7, 0, 0, 0, 0, 0);
        one("R6 push", 6, 0, 0, 0, 0, 8'h42);
        one("R7 pop", 7, 0, 0, 0, 0, 0);
        do_call(16'h0F0F);
        one("R6 push in sub", 6, 0, 0, 0, 0, 8'h11);
        one("R7 pop in sub", 7, 0, 0, 0, 0, 0);
        do_ret();
        one("R7 R10 pop stack", 7, 0, 0, 0, 0, 0);
        one("R7 R10 pop stack", 7, 0, 0, 0, 0, 0);
        chk("R11 idle port", int'(mem_we & mem_re), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog got=hung exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule